// File: doc/BRIEF.md
# Slave-clocked up-counting timer

This block is a 16-bit up-counter whose count clock is chosen at run time. In the default slave mode it advances on the system clock. When the slave-mode field selects trigger clocking, it advances instead on rising edges of one of four internal trigger lines, picked by a trigger-select field. Another timer's trigger output can drive these lines, so timers can be chained.

A 16-bit prescaler sits between the chosen clock and the counter. A prescaler setting of D lets one count through for every D+1 clock events. The prescaler setting is double-buffered. A working copy is taken whenever the timer is disabled, and again at each overflow. A write made while the timer runs therefore changes the count rate only from the next overflow onwards.

When the counter has reached the period value, the next count returns it to zero. That wrap sets a sticky overflow flag, which software clears, and produces a one-cycle pulse on the trigger output.

Top module: `slv_timer`

## Requirements
- R1: While reset is asserted, and directly after it, the count is 0, the overflow flag is 0 and the trigger output is 0.
- R2: With any slave-mode value other than 3'b111 and the timer enabled, the count rises by exactly one for every cfg_div+1 clock cycles. The first increment follows the (cfg_div+1)-th rising edge on which cfg_en is high.
- R3: A count event while the count is equal to or greater than cfg_period sets the count to 0, so the sequence runs 0 to cfg_period and repeats.
- R4: The overflow flag is set by the clock edge that wraps the count. It stays set until an edge at which ovf_clr is high and no wrap occurs. A clear on the same edge as a wrap leaves the flag set.
- R5: The trigger output is high for exactly the one cycle that follows each wrapping edge, which is the cycle in which the count first shows 0.
- R6: A change to cfg_div while the timer is enabled has no effect on the count rate until the next wrap. From that wrap on, the new division is used.
- R7: With slave mode 3'b111 and cfg_trig_sel in the range 0 to 3, each rising edge of trig_in[cfg_trig_sel] is one clock event for the prescaler. With cfg_div=0, an input that rises before clock edge 1 changes the count on clock edge 3.
- R8: With slave mode 3'b111 and cfg_trig_sel in the range 4 to 7, activity on the trigger inputs never advances the count.
- R9: While cfg_en is low the count holds its value. Raising cfg_en restarts the prescaler from zero with the current cfg_div, and counting continues from the held value.
- R10: In trigger mode, edges on trigger inputs other than the selected one do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Timer enable |
| cfg_period | input | 16 | Count value at which the next count wraps to 0 |
| cfg_div | input | 16 | Prescaler setting; divides by cfg_div+1 |
| cfg_trig_sel | input | 3 | Trigger line select; 0 to 3 valid, 4 to 7 select nothing |
| cfg_slave_mode | input | 3 | 3'b111 clocks the counter from the selected trigger; any other value clocks it from the system clock |
| trig_in | input | 4 | Asynchronous internal trigger inputs |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| trig_out_o | output | 1 | One-cycle pulse after each wrap |

## Verification
In system-clock mode, the count, the flag and the trigger output all change on the clock edge that consumes the enabling cycle. The bench therefore predicts, after every single edge, the number of increments as the integer quotient of enabled edges by cfg_div+1, and samples 1 ns after that edge. A trigger edge needs two synchronizer stages and an edge register before it counts. The bench therefore expects a count change exactly three edges after driving a trigger line high, and checks that the count has not changed one and two edges after. For the buffered prescaler, the clear-versus-wrap collision and the enable restart, the bench steps through exact edge sequences and compares each output with an edge-by-edge schedule derived from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned TMR_CNT_W  = 16;
    localparam int unsigned TMR_PSC_W  = 16;
    localparam int unsigned TMR_N_TRIG = 4;
    localparam int unsigned TMR_SEL_W  = 3;
    localparam int unsigned TMR_MODE_W = 3;
    localparam int unsigned TMR_SYNC   = 2;

    // slave-mode code that clocks the counter from the selected trigger
    localparam logic [TMR_MODE_W-1:0] SLV_TRIG_CLK = 3'b111;
endpackage

// File: rtl/tmr_trig_front.sv
module tmr_trig_front #(
    parameter int unsigned N_TRIG = 4,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              pulse_o
);
    typedef struct packed {
        logic [SYNC-1:0][N_TRIG-1:0] sync;
        logic [N_TRIG-1:0]           prev;
    } front_t;

    front_t q, d;
    logic [N_TRIG-1:0] edges;

    always_comb begin
        d = q;
        d.sync[0] = trig_i;
        for (int s = 1; s < SYNC; s++) begin
            d.sync[s] = q.sync[s-1];
        end
        d.prev = q.sync[SYNC-1];
        edges  = q.sync[SYNC-1] & ~q.prev;
        pulse_o = 1'b0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (sel_i == SEL_W'(i)) pulse_o = edges[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < N_TRIG; g++) begin : g_edge_chk
        AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            edges[g] |=> !edges[g]); // R7
    end
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [PSC_W-1:0] div_i,
    input  logic             reload_i,
    output logic             cnt_en_o
);
    typedef struct packed {
        logic [PSC_W-1:0] pcnt;
        logic [PSC_W-1:0] shadow;
    } psc_t;

    psc_t q, d;
    logic at_top;

    always_comb begin
        d        = q;
        at_top   = (q.pcnt == q.shadow);
        cnt_en_o = en_i & tick_i & at_top;
        if (!en_i) begin
            d.pcnt   = '0;
            d.shadow = div_i;
        end else begin
            if (tick_i) d.pcnt = at_top ? '0 : q.pcnt + PSC_W'(1);
            if (reload_i) begin
                d.pcnt   = '0;
                d.shadow = div_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !reload_i) |=> $stable(q.shadow)); // R6
    AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.pcnt <= q.shadow); // R2
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d     = q;
        ovf_o = cnt_en_i & (q.cnt >= period_i);
        if (cnt_en_i) d.cnt = ovf_o ? '0 : q.cnt + CNT_W'(1);
        cnt_o = q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (q.cnt == '0)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i |=> $stable(q.cnt)); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !ovf_o) |=> (q.cnt == $past(q.cnt) + CNT_W'(1))); // R2
endmodule

// File: rtl/slv_timer.sv
module slv_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = TMR_CNT_W,
    parameter int unsigned PSC_W  = TMR_PSC_W,
    parameter int unsigned N_TRIG = TMR_N_TRIG,
    parameter int unsigned SEL_W  = TMR_SEL_W,
    parameter int unsigned SYNC   = TMR_SYNC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_en,
    input  logic [CNT_W-1:0]      cfg_period,
    input  logic [PSC_W-1:0]      cfg_div,
    input  logic [SEL_W-1:0]      cfg_trig_sel,
    input  logic [TMR_MODE_W-1:0] cfg_slave_mode,
    input  logic [N_TRIG-1:0]     trig_in,
    input  logic                  ovf_clr,
    output logic [CNT_W-1:0]      cnt_o,
    output logic                  ovf_flag_o,
    output logic                  trig_out_o
);
    typedef struct packed {
        logic flag;
        logic tout;
    } top_t;

    top_t q, d;
    logic trig_pulse;
    logic tick;
    logic cnt_en;
    logic ovf;

    tmr_trig_front #(.N_TRIG(N_TRIG), .SEL_W(SEL_W), .SYNC(SYNC)) i_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig_in),
        .sel_i   (cfg_trig_sel),
        .pulse_o (trig_pulse)
    );

    tmr_presc #(.PSC_W(PSC_W)) i_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg_en),
        .tick_i   (tick),
        .div_i    (cfg_div),
        .reload_i (ovf),
        .cnt_en_o (cnt_en)
    );

    tmr_count #(.CNT_W(CNT_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en_i (cnt_en),
        .period_i (cfg_period),
        .cnt_o    (cnt_o),
        .ovf_o    (ovf)
    );

    always_comb begin
        tick   = (cfg_slave_mode == SLV_TRIG_CLK) ? trig_pulse : 1'b1;
        d      = q;
        d.flag = ovf | (q.flag & ~ovf_clr);
        d.tout = ovf;
        ovf_flag_o = q.flag;
        trig_out_o = q.tout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !ovf_clr) |=> ovf_flag_o); // R4
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf_flag_o); // R4
    AST_TOUT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out_o |-> (cnt_o == '0 && ovf_flag_o)); // R5
    AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_slave_mode == SLV_TRIG_CLK && cfg_trig_sel >= SEL_W'(N_TRIG)) |-> !cnt_en); // R8
    AST_NO_COUNT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !cnt_en); // R9
endmodule

// File: tb/test_slv_timer.sv
`timescale 1ns/1ps
module test_slv_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [15:0] cfg_period = '0;
    logic [15:0] cfg_div = '0;
    logic [2:0]  cfg_trig_sel = '0;
    logic [2:0]  cfg_slave_mode = '0;
    logic [3:0]  trig_in = '0;
    logic        ovf_clr = 1'b0;
    logic [15:0] cnt_o;
    logic        ovf_flag_o;
    logic        trig_out_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    slv_timer i_slv_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_en         (cfg_en),
        .cfg_period     (cfg_period),
        .cfg_div        (cfg_div),
        .cfg_trig_sel   (cfg_trig_sel),
        .cfg_slave_mode (cfg_slave_mode),
        .trig_in        (trig_in),
        .ovf_clr        (ovf_clr),
        .cnt_o          (cnt_o),
        .ovf_flag_o     (ovf_flag_o),
        .trig_out_o     (trig_out_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_en = 1'b0; ovf_clr = 1'b0; trig_in = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check("R1 cnt", cnt_o, 0);
        check("R1 flag", ovf_flag_o, 0);
        check("R1 trig_out", trig_out_o, 0);

        // R2 R3 R4 R5: system-clock sweep over divisions and periods
        for (int dv = 0; dv < 4; dv++) begin
            for (int pr = 0; pr < 5; pr++) begin
                do_reset();
                cfg_div = 16'(dv); cfg_period = 16'(pr);
                cfg_slave_mode = dv[0] ? 3'b101 : 3'b000;
                step();
                cfg_en = 1'b1;
                for (int k = 1; k <= (dv+1)*(pr+1)*2 + 2; k++) begin
                    int inc;
                    step();
                    inc = k / (dv+1);
                    check(inc <= pr ? "R2 cnt" : "R3 cnt", cnt_o, inc % (pr+1));
                    check("R4 flag", ovf_flag_o, (inc >= pr+1) ? 1 : 0);
                    check("R5 trig_out", trig_out_o,
                          ((k % (dv+1) == 0) && inc > 0 && (inc % (pr+1) == 0)) ? 1 : 0);
                end
            end
        end

        // R3: period lowered below the current count wraps on the next count
        do_reset();
        cfg_slave_mode = 3'b000; cfg_div = 0; cfg_period = 5;
        step();
        cfg_en = 1'b1;
        for (int k = 0; k < 4; k++) step();
        check("R3 pre", cnt_o, 4);
        cfg_period = 2;
        step();
        check("R3 wrap above period", cnt_o, 0);
        check("R4 flag above period", ovf_flag_o, 1);

        // R6: prescaler write waits for the next wrap
        do_reset();
        cfg_div = 0; cfg_period = 3;
        step();
        cfg_en = 1'b1;
        step(); step();
        check("R6 pre", cnt_o, 2);
        cfg_div = 3;
        step();
        check("R6 old rate", cnt_o, 3);
        step();
        check("R6 wrap", cnt_o, 0);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R6 new rate hold", cnt_o, 0);
        end
        step();
        check("R6 new rate step", cnt_o, 1);

        // R4: clear, and clear colliding with a wrap
        do_reset();
        cfg_div = 0; cfg_period = 1;
        step();
        cfg_en = 1'b1;
        step(); step();
        check("R4 set", ovf_flag_o, 1);
        ovf_clr = 1'b1;
        step();
        check("R4 cleared", ovf_flag_o, 0);
        step();
        check("R4 clear with wrap", ovf_flag_o, 1);
        step();
        check("R4 cleared again", ovf_flag_o, 0);
        ovf_clr = 1'b0;

        // R9: disable holds the count, enable restarts the prescaler
        do_reset();
        cfg_div = 3; cfg_period = 9;
        step();
        cfg_en = 1'b1;
        for (int k = 0; k < 6; k++) step();
        check("R9 pre", cnt_o, 1);
        cfg_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R9 hold", cnt_o, 1);
        end
        cfg_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R9 restart wait", cnt_o, 1);
        end
        step();
        check("R9 restart step", cnt_o, 2);

        // R7 R10: trigger clocking, every valid select
        for (int s = 0; s < 4; s++) begin
            do_reset();
            cfg_slave_mode = 3'b111; cfg_trig_sel = 3'(s);
            cfg_div = 0; cfg_period = 7;
            step();
            cfg_en = 1'b1;
            step();
            trig_in = 4'(1 << s);
            step(); check("R7 latency edge1", cnt_o, 0);
            step(); check("R7 latency edge2", cnt_o, 0);
            step(); check("R7 latency edge3", cnt_o, 1);
            step(); step();
            trig_in = '0;
            step(); step(); step();
            check("R7 one count per edge", cnt_o, 1);
            trig_in = ~4'(1 << s);
            for (int k = 0; k < 4; k++) step();
            trig_in = '0;
            for (int k = 0; k < 4; k++) step();
            check("R10 other inputs ignored", cnt_o, 1);
            for (int p = 0; p < 3; p++) begin
                trig_in = 4'(1 << s);
                step(); step(); step();
                trig_in = '0;
                step(); step(); step();
            end
            check("R7 pulse train", cnt_o, 4);
        end

        // R8: reserved selects produce no counts
        do_reset();
        cfg_slave_mode = 3'b111; cfg_div = 0; cfg_period = 7;
        step();
        cfg_en = 1'b1;
        for (int s = 4; s < 8; s++) begin
            cfg_trig_sel = 3'(s);
            trig_in = 4'hF;
            step(); step(); step();
            trig_in = '0;
            step(); step(); step();
            check("R8 reserved select", cnt_o, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule